// File: doc/BRIEF.md
# Serial Command Decoder for a Programmable-Gain Amplifier

This block receives 16-bit command words over a four-wire serial link in clock mode 0 and turns them into the static control state of a programmable-gain amplifier. That state is an 8-bit gain code, an 8-bit input-channel code and a power-down flag. Each word carries an instruction byte followed by a data byte. The instruction byte holds a 3-bit operation code in its top bits and a one-bit register select in its lowest bit. The block acts on a word only when chip select rises after exactly sixteen clocked bits. Any other bit count is dropped without effect.

The serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are found on the synchronized copies. The system clock must run at least four times faster than the serial clock. A one-cycle `upd_pulse` marks every accepted word. Data enters over the serial pins only and the outputs are static levels, so no port of this block uses a valid/ready handshake and there is no back-pressure. A host that sends words faster than they are accepted has no way to see this, and it must keep chip select high for at least four system clocks between words.

Top module: `pga_spi_ctrl`

## Requirements
- R1: The block shifts `spi_mosi` in MSB first on each rising edge of `spi_sck` while `spi_csn` is low. Received word bits 15:13 are the operation code, bit 8 is the register select, and bits 7:0 are the data.
- R2: Operation code 3'b010 loads the data byte into `gain_code` when the select bit is 0, or into `chan_code` when it is 1. Word bits 12:9 have no effect.
- R3: The outputs change only on the third rising edge of `clk` after `spi_csn` goes high at the pin. Before that edge they keep their previous values.
- R4: When chip select rises after any bit count other than 16 (for example 8, 15 or 17), the word is discarded. `gain_code`, `chan_code` and `shdn` stay unchanged, and no `upd_pulse` is produced.
- R5: Operation code 3'b001 sets `shdn`. Sending the same code again while `shdn` is already high leaves it high.
- R6: A load operation (3'b010) clears `shdn` and is also carried out in the same update.
- R7: Operation codes 3'b000, 3'b011 and 3'b1xx change nothing, whatever the select bit and data byte hold. They do not clear `shdn`.
- R8: Each falling edge of chip select clears the bit count. A word that was cut short, or a bare low-then-high pulse on chip select, has no effect on the word that follows.
- R9: `upd_pulse` is high for exactly one cycle for each accepted word, whatever its operation code. It is high in the same cycle in which that word's effect first appears on the outputs.
- R10: While reset is held and after it is released, `shdn` and `upd_pulse` are 0. `gain_code` and `chan_code` have no defined value until a load operation writes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_csn | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data in |
| gain_code | output | 8 | Stored gain setting |
| chan_code | output | 8 | Stored channel setting |
| shdn | output | 1 | Power-down request |
| upd_pulse | output | 1 | One-cycle strobe for each accepted word |

## Verification
The bench sends words of 8, 15, 16 and 17 bits. A block that counted bits loosely would apply a truncated or overlong word and change a register or raise the strobe. It repeats power-down while already powered down and mixes no-operation and reserved codes that have the select bit and data bits set. A decoder that toggled the flag, or that looked at the select bit for a non-load code, would then corrupt the outputs or wake the amplifier. A bare chip-select toggle and an aborted word are each followed by a valid load, which catches a counter that fails to clear on the falling edge. Every output is compared on every clock, which exposes a synchronizer depth or update cycle that is off by one.

// File: rtl/pga_spi_pkg.sv
`timescale 1ns/1ps
package pga_spi_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 8;
  localparam int OPC_MSB    = FRAME_BITS - 1;
  localparam int OPC_LSB    = FRAME_BITS - 3;
  localparam int SEL_BIT    = DATA_W;

  localparam logic [2:0] OPC_SLEEP = 3'b001;
  localparam logic [2:0] OPC_LOAD  = 3'b010;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_SLEEP = 2'd1,
    ACT_LOAD  = 2'd2
  } act_e;

  typedef struct packed {
    act_e              act;
    logic              sel_chan;
    logic [DATA_W-1:0] data;
  } op_t;

  function automatic op_t decode_word(input logic [FRAME_BITS-1:0] w);
    op_t o;
    o.sel_chan = w[SEL_BIT];
    o.data     = w[DATA_W-1:0];
    case (w[OPC_MSB:OPC_LSB])
      OPC_SLEEP: o.act = ACT_SLEEP;
      OPC_LOAD:  o.act = ACT_LOAD;
      default:   o.act = ACT_NONE;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/pga_sync.sv
`timescale 1ns/1ps
module pga_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else             stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pga_spi_rx.sv
`timescale 1ns/1ps
module pga_spi_rx
  import pga_spi_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csn_s,
  input  logic             sck_s,
  input  logic             mosi_s,
  output logic             cs_rise,
  output logic             frame_full,
  output logic             frame_vld,
  output logic [NBITS-1:0] frame_word
);
  localparam int CNT_W   = $clog2(NBITS + 2);
  localparam int CNT_TOP = NBITS + 1;

  logic             csn_q, sck_q;
  logic             cs_fall, sck_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic [NBITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  assign cs_fall  = csn_q & ~csn_s;
  assign cs_rise  = ~csn_q & csn_s;
  assign sck_rise = ~sck_q & sck_s & ~csn_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (cs_fall || cs_rise) begin
      bit_cnt <= '0;
    end else if (sck_rise && (bit_cnt != CNT_W'(CNT_TOP))) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        shreg <= '0;
    else if (sck_rise) shreg <= {shreg[NBITS-2:0], mosi_s};
  end

  assign frame_full = (bit_cnt == CNT_W'(NBITS));
  assign frame_vld  = cs_rise & frame_full;
  assign frame_word = shreg;
endmodule

// File: rtl/pga_cmd_regs.sv
`timescale 1ns/1ps
module pga_cmd_regs
  import pga_spi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_vld,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic [DATA_W-1:0]     gain_code,
  output logic [DATA_W-1:0]     chan_code,
  output logic                  shdn,
  output logic                  upd_pulse
);
  op_t op;
  logic load_gain, load_chan;

  assign op        = decode_word(frame_word);
  assign load_gain = frame_vld && (op.act == ACT_LOAD) && !op.sel_chan;
  assign load_chan = frame_vld && (op.act == ACT_LOAD) &&  op.sel_chan;

  always_ff @(posedge clk) begin
    if (load_gain) gain_code <= op.data;
    if (load_chan) chan_code <= op.data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shdn      <= 1'b0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= frame_vld;
      if (frame_vld) begin
        case (op.act)
          ACT_SLEEP: shdn <= 1'b1;
          ACT_LOAD:  shdn <= 1'b0;
          default:   shdn <= shdn;
        endcase
      end
    end
  end
endmodule

// File: rtl/pga_spi_ctrl.sv
`timescale 1ns/1ps
module pga_spi_ctrl
  import pga_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic [DATA_W-1:0] gain_code,
  output logic [DATA_W-1:0] chan_code,
  output logic              shdn,
  output logic              upd_pulse
);
  logic [2:0]            pins_s;
  logic                  cs_rise, frame_full, frame_vld;
  logic [FRAME_BITS-1:0] frame_word;

  pga_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_csn, spi_sck, spi_mosi}),
    .q    (pins_s)
  );

  pga_spi_rx #(.NBITS(FRAME_BITS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_s     (pins_s[2]),
    .sck_s     (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .cs_rise   (cs_rise),
    .frame_full(frame_full),
    .frame_vld (frame_vld),
    .frame_word(frame_word)
  );

  pga_cmd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_vld (frame_vld),
    .frame_word(frame_word),
    .gain_code (gain_code),
    .chan_code (chan_code),
    .shdn      (shdn),
    .upd_pulse (upd_pulse)
  );
endmodule

// File: rtl/pga_spi_ctrl_chk.sv
`timescale 1ns/1ps
module pga_spi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] gain_code,
  input logic [7:0] chan_code,
  input logic       shdn,
  input logic       upd_pulse,
  input logic       cs_rise,
  input logic       frame_full
);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);

  assert_pulse_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(cs_rise));

  assert_pulse_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(frame_full));

  assert_gain_moves_on_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_code) |-> upd_pulse);

  assert_chan_moves_on_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_code) |-> upd_pulse);

  assert_shdn_moves_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shdn) |-> upd_pulse);
endmodule

bind pga_spi_ctrl pga_spi_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gain_code (gain_code),
  .chan_code (chan_code),
  .shdn      (shdn),
  .upd_pulse (upd_pulse),
  .cs_rise   (cs_rise),
  .frame_full(frame_full)
);

// File: tb/pga_spi_ctrl_bench.sv
`timescale 1ns/1ps
module pga_spi_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_csn = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_mosi = 1'b0;
  logic [7:0] gain_code, chan_code;
  logic       shdn, upd_pulse;

  always #2.5 clk = ~clk;

  pga_spi_ctrl u_pga_spi_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_csn  (spi_csn),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .gain_code(gain_code),
    .chan_code(chan_code),
    .shdn     (shdn),
    .upd_pulse(upd_pulse)
  );

  // reference model state, written only by the stimulus block
  logic [7:0] m_gain = 8'h00, m_chan = 8'h00;
  bit         m_gain_ok = 0, m_chan_ok = 0;
  bit         m_shdn = 0, m_pulse = 0;
  bit         done = 0, checking = 0;
  string      cur_req = "R10";

  int checks = 0, errors = 0, cycles = 0;
  localparam int WATCHDOG = 150000;
  localparam int HALF = 4;

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      checks++;
      if (shdn !== m_shdn) begin
        errors++;
        $display("FAIL %s shdn actual %0d expected %0d at cycle %0d", cur_req, shdn, m_shdn, cycles);
      end
      checks++;
      if (upd_pulse !== m_pulse) begin
        errors++;
        $display("FAIL %s upd_pulse actual %0d expected %0d at cycle %0d", cur_req, upd_pulse, m_pulse, cycles);
      end
      if (m_gain_ok) begin
        checks++;
        if (gain_code !== m_gain) begin
          errors++;
          $display("FAIL %s gain_code actual %02h expected %02h at cycle %0d", cur_req, gain_code, m_gain, cycles);
        end
      end
      if (m_chan_ok) begin
        checks++;
        if (chan_code !== m_chan) begin
          errors++;
          $display("FAIL %s chan_code actual %02h expected %02h at cycle %0d", cur_req, chan_code, m_chan, cycles);
        end
      end
    end
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      done = 1;
    end
    if (done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input logic [2:0] opc, input logic [3:0] pad,
                                     input logic sel, input logic [7:0] dat);
    return {opc, pad, sel, dat};
  endfunction

  // apply an accepted word to the model (R2, R5, R6, R7)
  task automatic model_apply(input logic [15:0] w);
    if (w[15:13] == 3'b010) begin
      if (w[8]) begin m_chan = w[7:0]; m_chan_ok = 1; end
      else      begin m_gain = w[7:0]; m_gain_ok = 1; end
      m_shdn = 0;
    end else if (w[15:13] == 3'b001) begin
      m_shdn = 1;
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // send n bits MSB first (R1); accepted only when n is 16 (R4)
  task automatic send(input logic [31:0] bits, input int n);
    @(negedge clk);
    spi_csn = 1'b0;
    wait_neg(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = bits[i];
      wait_neg(HALF);
      spi_sck = 1'b1;
      wait_neg(HALF);
      spi_sck = 1'b0;
    end
    wait_neg(HALF);
    spi_csn = 1'b1;
    // outputs move on the third rising edge after the pin rises (R3)
    repeat (3) @(posedge clk);
    #1;
    if (n == 16) begin
      model_apply(bits[15:0]);
      m_pulse = 1;
    end
    @(posedge clk);
    #1;
    m_pulse = 0;
    wait_neg(HALF);
  endtask

  initial begin
    wait_neg(4);
    cur_req = "R10";
    checking = 1;
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(4);

    cur_req = "R1";
    send(mk(3'b010, 4'h0, 1'b0, 8'h80), 16);
    send(mk(3'b010, 4'h0, 1'b0, 8'h01), 16);
    send(mk(3'b010, 4'h0, 1'b1, 8'hA5), 16);

    cur_req = "R2";
    send(mk(3'b010, 4'hF, 1'b0, 8'h5A), 16);
    send(mk(3'b010, 4'h6, 1'b1, 8'h3C), 16);

    cur_req = "R5";
    send(mk(3'b001, 4'h0, 1'b0, 8'h00), 16);
    send(mk(3'b001, 4'hF, 1'b1, 8'hFF), 16);

    cur_req = "R7";
    send(mk(3'b000, 4'hF, 1'b1, 8'hFF), 16);
    send(mk(3'b011, 4'h0, 1'b0, 8'h77), 16);
    send(mk(3'b100, 4'h0, 1'b1, 8'h12), 16);
    send(mk(3'b110, 4'h0, 1'b0, 8'h34), 16);
    send(mk(3'b111, 4'hA, 1'b1, 8'h56), 16);

    cur_req = "R6";
    send(mk(3'b010, 4'h0, 1'b1, 8'h81), 16);

    cur_req = "R4";
    send({16'h0, 8'h40, 8'h00}, 8);
    send({17'h0, mk(3'b001, 4'h0, 1'b0, 8'h00) >> 1}, 15);
    send({15'h0, 1'b0, mk(3'b010, 4'h0, 1'b0, 8'hEE)}, 17);
    send({15'h0, 1'b1, mk(3'b001, 4'h0, 1'b0, 8'h00)}, 17);

    cur_req = "R8";
    send(32'h0, 0);
    send(mk(3'b010, 4'h0, 1'b0, 8'h11), 16);
    send({27'h0, 5'b01011}, 5);
    send(mk(3'b010, 4'h0, 1'b1, 8'h22), 16);

    cur_req = "R9";
    send(mk(3'b001, 4'h0, 1'b0, 8'h00), 16);
    send(mk(3'b000, 4'h0, 1'b0, 8'h00), 16);

    cur_req = "R3";
    send(mk(3'b010, 4'h0, 1'b0, 8'hC3), 16);

    wait_neg(8);
    done = 1;
  end
endmodule